// File: doc/BRIEF.md
# Selectable-Source Watchdog Counter with Paired Clear

The block is a watchdog counter for a small controller. It counts clock-enable ticks from one of three sources: a dedicated slow oscillator, the system clock divided by four, or a real-time oscillator. The ticks pass through a prescaler and then a main counter. When both stages roll over, the block raises a reset request. In normal running the request is a full chip reset and a sticky time-out flag is set. While the core is halted the request is a warm reset, and the flag is left alone.

Software must restart the count before it expires. A mode input selects how it does so. In single mode one clear strobe is enough. In paired mode two distinct strobes must both be seen, in either order. The block remembers each one until the counter is cleared. The counter is also cleared when the core enters halt, and by reset. An enable input turns the whole function off.

Top module: `wdg_top`

## Requirements
- R1: When `rst` is high at a clock edge, the counter, both seen flags, `timeout_flag`, `chip_rst_req` and `warm_rst_req` all go to 0 after that edge.
- R2: `src_sel` picks the tick that advances the count: 0 selects `tick_osc`, 1 selects `tick_sys4`, and 2 or 3 select `tick_rtc`. Ticks on the other two inputs do not advance the count.
- R3: An overflow occurs on the 2^(PRE_W+CNT_W)-th selected tick after the last clear (32 ticks with PRE_W=2, CNT_W=3). The count then wraps to zero and continues.
- R4: An overflow with `halt` low makes `chip_rst_req` high for exactly the one cycle after the edge that accepted the final tick, and sets `timeout_flag` at the same edge.
- R5: An overflow with `halt` high makes `warm_rst_req` pulse for one cycle instead. `chip_rst_req` stays low and `timeout_flag` is left as it was.
- R6: A 0-to-1 change of `halt` while enabled clears the counter.
- R7: With `src_sel`=1 and `halt` high, `tick_sys4` pulses are ignored and the count holds its value.
- R8: In single mode (`dual_mode`=0), `clr_single` clears the counter, and `clr_first` and `clr_second` have no effect.
- R9: In paired mode (`dual_mode`=1), the counter clears only once both `clr_first` and `clr_second` have been seen since the last clear. They may come in either order or in the same cycle. `clr_single` has no effect in this mode.
- R10: While `wd_en` is 0, the count is held at zero, no reset request is raised, and the clear strobes do not change `timeout_flag`.
- R11: `timeout_flag` stays set until `rst` or an accepted software clear (single, or a completed pair).
- R12: A clear takes priority over a tick in the same cycle. That tick is not counted and cannot cause an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high external reset |
| tick_osc | input | 1 | Dedicated slow oscillator tick |
| tick_sys4 | input | 1 | System clock / 4 tick |
| tick_rtc | input | 1 | Real-time oscillator tick |
| src_sel | input | 2 | Tick source select |
| wd_en | input | 1 | Watchdog enable option |
| dual_mode | input | 1 | 0: single clear, 1: paired clear |
| clr_single | input | 1 | Single clear strobe |
| clr_first | input | 1 | First paired clear strobe |
| clr_second | input | 1 | Second paired clear strobe |
| halt | input | 1 | Core halted indication |
| chip_rst_req | output | 1 | Full chip reset request pulse |
| warm_rst_req | output | 1 | Warm reset request pulse |
| timeout_flag | output | 1 | Sticky time-out status |

## Verification
The directed tests first count exactly one tick short of expiry and then one tick more. This pins the period of the prescaler and main counter. Further directed tests drive ticks on the unselected sources, send the paired strobes separately with a single strobe between them, and enter halt partway through a count. Each of these separates a correct clear or gating from one that is missing or premature. A seeded random phase then mixes source changes, mode switches, halts, disables and clears against a cycle model, which exposes errors in priority and ordering when events coincide.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        SRC_OSC  = 2'd0,
        SRC_SYS4 = 2'd1,
        SRC_RTC  = 2'd2,
        SRC_RTC2 = 2'd3
    } wdg_src_e;

    typedef struct packed {
        logic osc;
        logic sys4;
        logic rtc;
    } wdg_ticks_t;

    typedef struct packed {
        logic single;
        logic first;
        logic second;
    } wdg_clr_t;

    typedef struct packed {
        logic chip;
        logic warm;
    } wdg_req_t;

    function automatic logic wdg_pick(input wdg_src_e s, input wdg_ticks_t t);
        logic r;
        case (s)
            SRC_OSC:  r = t.osc;
            SRC_SYS4: r = t.sys4;
            default:  r = t.rtc;
        endcase
        return r;
    endfunction

    function automatic logic wdg_stalled(input wdg_src_e s, input logic halted);
        return (s == SRC_SYS4) && halted;
    endfunction

endpackage

// File: rtl/wdg_tick_mux.sv
module wdg_tick_mux
    import wdg_pkg::*;
(
    input  wdg_ticks_t ticks,
    input  wdg_src_e   src,
    input  logic       halt,
    input  logic       en,
    output logic       tick_out
);
    always_comb begin
        tick_out = en && wdg_pick(src, ticks) && !wdg_stalled(src, halt);
    end
endmodule

// File: rtl/wdg_clear_ctl.sv
module wdg_clear_ctl
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     dual,
    input  wdg_clr_t clr,
    input  logic     halt,
    output logic     sw_clr,
    output logic     clr_evt
);
    logic seen_first, seen_second, halt_q, halt_entry;

    always_comb begin
        halt_entry = halt && !halt_q;
        if (dual)
            sw_clr = en && (seen_first || clr.first) && (seen_second || clr.second);
        else
            sw_clr = en && clr.single;
        clr_evt = sw_clr || (en && halt_entry);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
        end else begin
            halt_q <= halt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en || clr_evt) begin
            seen_first  <= 1'b0;
            seen_second <= 1'b0;
        end else if (dual) begin
            seen_first  <= seen_first  || clr.first;
            seen_second <= seen_second || clr.second;
        end
    end

    // R9: a lone first strobe in paired mode is remembered
    p_first_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (en && dual && clr.first && !clr.second && !seen_second && !halt_entry)
        |=> seen_first);

    // R8: paired strobes never arm anything in single mode
    p_single_no_arm_r8: assert property (@(posedge clk) disable iff (rst)
        (!dual && !seen_first && !seen_second) |=> (!seen_first && !seen_second));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   clear,
    input  logic                   tick,
    output logic                   ovf,
    output logic [PRE_W+CNT_W-1:0] cnt_o
);
    localparam int TOT_W = PRE_W + CNT_W;
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] main_q;
    logic             pre_wrap;

    always_comb begin
        pre_wrap = &pre_q;
        ovf      = en && tick && !clear && pre_wrap && (&main_q);
        cnt_o    = {main_q, pre_q};
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !en) begin
            pre_q  <= '0;
            main_q <= '0;
        end else if (tick) begin
            pre_q <= pre_q + PRE_ONE;
            if (pre_wrap)
                main_q <= main_q + CNT_ONE;
        end
    end

    // R12: a clear wins over a tick and leaves the count at zero
    p_clear_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (clear || !en) |=> (cnt_o == '0));

    // R3: an overflow wraps the whole count back to zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt_o == TOT_W'(0)));
endmodule

// File: rtl/wdg_report.sv
module wdg_report
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ovf,
    input  logic     halt,
    input  logic     sw_clr,
    output wdg_req_t req,
    output logic     flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= '0;
            flag <= 1'b0;
        end else begin
            req.chip <= ovf && !halt;
            req.warm <= ovf && halt;
            if (ovf && !halt)
                flag <= 1'b1;
            else if (sw_clr)
                flag <= 1'b0;
        end
    end

    // R5: the two kinds of request never coincide
    p_req_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(req.chip && req.warm));

    // R4: a chip request always comes with the status flag set
    p_flag_with_chip_r4: assert property (@(posedge clk) disable iff (rst)
        req.chip |-> flag);

    // R5: a warm request leaves the flag untouched
    p_warm_keeps_flag_r5: assert property (@(posedge clk) disable iff (rst)
        ovf && halt |=> $stable(flag));
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_osc,
    input  logic       tick_sys4,
    input  logic       tick_rtc,
    input  logic [1:0] src_sel,
    input  logic       wd_en,
    input  logic       dual_mode,
    input  logic       clr_single,
    input  logic       clr_first,
    input  logic       clr_second,
    input  logic       halt,
    output logic       chip_rst_req,
    output logic       warm_rst_req,
    output logic       timeout_flag
);
    localparam int TOT_W = PRE_W + CNT_W;

    wdg_ticks_t       ticks;
    wdg_clr_t         clr;
    wdg_src_e         src;
    wdg_req_t         req;
    logic             tick, sw_clr, clr_evt, ovf;
    logic [TOT_W-1:0] cnt;

    always_comb begin
        ticks = '{osc: tick_osc, sys4: tick_sys4, rtc: tick_rtc};
        clr   = '{single: clr_single, first: clr_first, second: clr_second};
        src   = wdg_src_e'(src_sel);
    end

    wdg_tick_mux u_mux (
        .ticks(ticks), .src(src), .halt(halt), .en(wd_en), .tick_out(tick)
    );

    wdg_clear_ctl u_clr (
        .clk(clk), .rst(rst), .en(wd_en), .dual(dual_mode), .clr(clr),
        .halt(halt), .sw_clr(sw_clr), .clr_evt(clr_evt)
    );

    wdg_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .en(wd_en), .clear(clr_evt), .tick(tick),
        .ovf(ovf), .cnt_o(cnt)
    );

    wdg_report u_rep (
        .clk(clk), .rst(rst), .ovf(ovf), .halt(halt), .sw_clr(sw_clr),
        .req(req), .flag(timeout_flag)
    );

    always_comb begin
        chip_rst_req = req.chip;
        warm_rst_req = req.warm;
    end

    // R7: halted with the divided system clock selected, the count is frozen
    p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (wd_en && src_sel == 2'd1 && halt && !clr_evt) |=> $stable(cnt));

    // R10: disabled, no request of either kind follows
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> (!chip_rst_req && !warm_rst_req));

    // R1: reset leaves outputs low
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!chip_rst_req && !warm_rst_req && !timeout_flag));
endmodule

// File: tb/wdg_top_tb.sv
module wdg_top_tb;
    localparam int PRE_W = 2;
    localparam int CNT_W = 3;
    localparam int TOT   = 1 << (PRE_W + CNT_W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_osc = 0, tick_sys4 = 0, tick_rtc = 0;
    logic [1:0] src_sel = 2'd0;
    logic wd_en = 0, dual_mode = 0, clr_single = 0, clr_first = 0, clr_second = 0, halt = 0;
    logic chip_rst_req, warm_rst_req, timeout_flag;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    int   m_cnt = 0;
    logic m_s1 = 0, m_s2 = 0, m_flag = 0, m_hq = 0, m_chip = 0, m_warm = 0;

    always #10 clk = ~clk;

    wdg_top #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .tick_osc(tick_osc), .tick_sys4(tick_sys4),
        .tick_rtc(tick_rtc), .src_sel(src_sel), .wd_en(wd_en), .dual_mode(dual_mode),
        .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
        .halt(halt), .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req),
        .timeout_flag(timeout_flag)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic sel_tick();
        case (src_sel)
            2'd0:    return tick_osc;
            2'd1:    return tick_sys4 && !halt;
            default: return tick_rtc;
        endcase
    endfunction

    function automatic void model_edge();
        logic sw, entry, tk;
        m_chip = 0;
        m_warm = 0;
        if (rst) begin
            m_cnt = 0; m_s1 = 0; m_s2 = 0; m_flag = 0; m_hq = 0;
            return;
        end
        if (wd_en) begin
            sw    = dual_mode ? ((m_s1 || clr_first) && (m_s2 || clr_second)) : clr_single;
            entry = halt && !m_hq;
            tk    = sel_tick();
            if (sw || entry) begin
                m_cnt = 0; m_s1 = 0; m_s2 = 0;
                if (sw) m_flag = 0;
            end else begin
                if (dual_mode) begin
                    m_s1 = m_s1 || clr_first;
                    m_s2 = m_s2 || clr_second;
                end
                if (tk) begin
                    if (m_cnt == TOT - 1) begin
                        m_cnt = 0;
                        if (halt) m_warm = 1;
                        else begin m_chip = 1; m_flag = 1; end
                    end else m_cnt++;
                end
            end
        end else begin
            m_cnt = 0; m_s1 = 0; m_s2 = 0;
        end
        m_hq = halt;
    endfunction

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R4 chip_rst_req", chip_rst_req, m_chip);
        chk("R5 warm_rst_req", warm_rst_req, m_warm);
        chk("R11 timeout_flag", timeout_flag, m_flag);
    endtask

    task automatic ticks(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            tick_osc  = (which == 0);
            tick_sys4 = (which == 1);
            tick_rtc  = (which == 2);
            step();
        end
        tick_osc = 0; tick_sys4 = 0; tick_rtc = 0;
    endtask

    task automatic pulse_clr(input logic s, input logic f, input logic sc);
        clr_single = s; clr_first = f; clr_second = sc;
        step();
        clr_single = 0; clr_first = 0; clr_second = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5150));
        @(negedge clk);
        step(); step();
        rst = 0;
        // R1 reset state
        chk("R1 chip", chip_rst_req, 1'b0);
        chk("R1 warm", warm_rst_req, 1'b0);
        chk("R1 flag", timeout_flag, 1'b0);

        wd_en = 1; dual_mode = 0; src_sel = 2'd0;
        ticks(0, TOT - 1);
        chk("R3 no pulse one short", chip_rst_req, 1'b0);
        ticks(0, 1);
        chk("R3 pulse at full period", chip_rst_req, 1'b1);
        chk("R4 flag set", timeout_flag, 1'b1);
        step();
        chk("R4 single-cycle pulse", chip_rst_req, 1'b0);

        // R2 source selection
        ticks(1, 40); ticks(2, 40);
        chk("R2 unselected ignored", chip_rst_req, 1'b0);
        src_sel = 2'd2;
        ticks(2, TOT);
        chk("R2 rtc selected", chip_rst_req, 1'b1);
        src_sel = 2'd0;

        // R11 sticky flag cleared by software
        chk("R11 still set", timeout_flag, 1'b1);
        pulse_clr(1, 0, 0);
        chk("R11 cleared", timeout_flag, 1'b0);

        // R8 paired strobes ignored in single mode
        ticks(0, 20);
        pulse_clr(0, 1, 1);
        ticks(0, TOT - 21);
        chk("R8 no pulse", chip_rst_req, 1'b0);
        ticks(0, 1);
        chk("R8 paired strobes ignored", chip_rst_req, 1'b1);

        // R9 paired mode, reverse order, single strobe ignored
        dual_mode = 1;
        ticks(0, 20);
        pulse_clr(0, 0, 1);
        pulse_clr(1, 0, 0);
        ticks(0, 10);
        chk("R9 half pair no clear", chip_rst_req, 1'b0);
        pulse_clr(0, 1, 0);
        ticks(0, TOT - 1);
        chk("R9 pair cleared", chip_rst_req, 1'b0);
        ticks(0, 1);
        chk("R9 expiry after pair", chip_rst_req, 1'b1);

        // R6 / R5 halt entry and warm request
        pulse_clr(0, 1, 1);
        ticks(0, 20);
        halt = 1;
        step();
        ticks(0, TOT - 1);
        chk("R6 halt entry cleared", warm_rst_req, 1'b0);
        ticks(0, 1);
        chk("R5 warm pulse", warm_rst_req, 1'b1);
        chk("R5 no chip", chip_rst_req, 1'b0);
        chk("R5 flag unchanged", timeout_flag, 1'b0);

        // R7 divided system clock stalls under halt
        src_sel = 2'd1;
        ticks(1, 40);
        chk("R7 stalled", warm_rst_req, 1'b0);
        halt = 0;
        step();
        ticks(1, TOT - 1);
        chk("R7 held count", chip_rst_req, 1'b0);
        ticks(1, 1);
        chk("R7 resumes", chip_rst_req, 1'b1);

        // R12 clear beats a simultaneous tick
        src_sel = 2'd0; dual_mode = 0;
        pulse_clr(1, 0, 0);
        ticks(0, TOT - 1);
        tick_osc = 1; clr_single = 1;
        step();
        tick_osc = 0; clr_single = 0;
        chk("R12 no overflow", chip_rst_req, 1'b0);
        ticks(0, TOT - 1);
        chk("R12 tick not counted", chip_rst_req, 1'b0);
        ticks(0, 1);
        chk("R12 full period after", chip_rst_req, 1'b1);

        // R10 disabled
        wd_en = 0;
        ticks(0, 100);
        chk("R10 no request", chip_rst_req, 1'b0);
        pulse_clr(1, 0, 0);
        chk("R10 clear ignored", timeout_flag, 1'b1);
        wd_en = 1;
        ticks(0, TOT - 1);
        chk("R10 count held at zero", chip_rst_req, 1'b0);
        ticks(0, 1);
        chk("R10 re-enabled expiry", chip_rst_req, 1'b1);

        // constrained random phase against the model
        for (int c = 0; c < 6000; c++) begin
            rst        = ($urandom % 700) == 0;
            if (($urandom % 60) == 0) wd_en = ~wd_en;
            if (($urandom % 300) == 0) dual_mode = ~dual_mode;
            if (($urandom % 150) == 0) src_sel = 2'($urandom % 4);
            if (($urandom % 90) == 0) halt = ~halt;
            tick_osc   = $urandom % 2;
            tick_sys4  = $urandom % 2;
            tick_rtc   = $urandom % 2;
            clr_single = ($urandom % 120) == 0;
            clr_first  = ($urandom % 100) == 0;
            clr_second = ($urandom % 100) == 0;
            step();
        end
        finish_run();
    end
endmodule